// File: doc/BRIEF.md
# Programmable-Priority Interrupt Winner Resolver

This block looks at the current interrupt state of up to forty sources and reports which one should be serviced next, once for the normal interrupt line (IRQ) and once for the fast line (FIQ). Each source has a pending bit, an enable bit and a steering bit that sends it to FIQ when set or to IRQ when clear. These bits arrive as two 32-bit banks per kind. Priority does not come from source numbering. It comes from a table of forty slots: each slot names a source, and a lower slot index means higher priority.

The result is a single 32-bit status word. The upper half describes the IRQ winner and the lower half describes the FIQ winner. A half that has no winner carries a fixed "nothing" code. The block holds no state, so the word follows its inputs within the same cycle. The registers that feed it, and the read path that returns the word, belong to the surrounding controller.

Top module: `hir_resolver`

## Requirements
- R1: Slot i is the 32-bit field `slot_cfg[32*i+31 : 32*i]`. Bit 31 of the field is the slot's enable flag and bits 5:0 are the source ID it names. Bits 30:6 have no effect on the status word.
- R2: A slot takes part only when its enable flag is 1 and its ID is below 40. Slots that are disabled or name IDs 40..63 never produce a winner.
- R3: An ID below 32 selects bit ID of the low bank (`*_lo`). An ID of 32 or more selects bit ID−32 of the high bank (`*_hi`).
- R4: A named source counts as an FIQ candidate when it is pending, enabled and steered (steer bit 1). It counts as an IRQ candidate when it is pending, enabled and not steered. A source that is not enabled is never a candidate.
- R5: Among the participating slots whose source is a candidate, the lowest slot index wins. IRQ and FIQ are resolved independently of each other.
- R6: On an FIQ winner, status bit 15 is 1 and bits 5:0 hold the winning ID. On an IRQ winner, bit 31 is 1 and bits 21:16 hold the winning ID.
- R7: With no FIQ winner, bits 15:0 read 0x003F. With no IRQ winner, bits 31:16 read 0x003F. With neither, the word is 0x003F003F.
- R8: Status bits 14:6 and 30:22 always read 0.
- R9: Several slots may name the same source. The outcome is still decided by the lowest-index participating active slot.
- R10: The status word is a pure combinational function of the current inputs. A change in the inputs is visible without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_lo | input | 32 | Pending bits, sources 0..31 |
| pend_hi | input | 32 | Pending bits, sources 32..63 (only 32..39 used) |
| en_lo | input | 32 | Enable bits, sources 0..31 |
| en_hi | input | 32 | Enable bits, sources 32..63 |
| steer_lo | input | 32 | FIQ steering bits, sources 0..31 |
| steer_hi | input | 32 | FIQ steering bits, sources 32..63 |
| slot_cfg | input | 1280 | Forty 32-bit priority slot fields, slot 0 in the lowest bits |
| status | output | 32 | Winner word: IRQ half 31:16, FIQ half 15:0 |

## Verification
The bench targets IDs 32..39, which a design decoding only the low bank would report as active using the wrong bits. It also targets IDs 40..63 with every source active: a design that skipped the range check would name a phantom winner instead of returning 0x003F. Other corner cases are several slots competing, duplicate IDs in the slot table, and a higher slot holding an FIQ source while a lower one holds an IRQ source. A resolver that picked by source number, by highest slot, or with the two lines coupled would report the wrong ID in one half. Noise in slot bits 30:6, disabled sources and fully idle inputs check that inputs which do not matter leave the fixed codes and zero bits untouched.

// File: rtl/hir_pkg.sv
package hir_pkg;
  localparam int unsigned HIR_ID_W      = 6;
  localparam int unsigned HIR_SLOT_W    = 32;
  localparam int unsigned HIR_SLOT_VBIT = 31;
  localparam int unsigned HIR_BANK_W    = 32;
  localparam logic [HIR_ID_W-1:0] HIR_NONE_ID = '1;

  // One 16-bit half of the status word: valid flag on top, id at the bottom.
  function automatic logic [15:0] hir_half(input logic v, input logic [HIR_ID_W-1:0] id);
    logic [15:0] h;
    h = '0;
    h[15] = v;
    h[HIR_ID_W-1:0] = v ? id : HIR_NONE_ID;
    return h;
  endfunction
endpackage

// File: rtl/hir_src_qualify.sv
module hir_src_qualify
  import hir_pkg::*;
#(
  parameter int unsigned NSRC   = 40,
  parameter int unsigned BANK_W = HIR_BANK_W
) (
  input  logic [2*BANK_W-1:0] pend,
  input  logic [2*BANK_W-1:0] en,
  input  logic [2*BANK_W-1:0] steer,
  output logic [NSRC-1:0]     act_irq,
  output logic [NSRC-1:0]     act_fiq
);
  localparam int unsigned SPARE = 2*BANK_W - NSRC;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic live;
    assign live       = pend[s] & en[s];
    assign act_fiq[s] = live & steer[s];
    assign act_irq[s] = live & ~steer[s];
  end

  if (SPARE > 0) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^{pend[2*BANK_W-1:NSRC], en[2*BANK_W-1:NSRC], steer[2*BANK_W-1:NSRC]};
  end

  // R4: a source is never a candidate for both lines at once
  always_comb begin
    a_r4_lines_exclusive: assert ((act_irq & act_fiq) == '0);
  end
endmodule

// File: rtl/hir_slot_eval.sv
module hir_slot_eval
  import hir_pkg::*;
#(
  parameter int unsigned NSLOT = 40,
  parameter int unsigned NSRC  = 40
) (
  input  logic [NSLOT*HIR_SLOT_W-1:0] slot_cfg,
  input  logic [NSRC-1:0]             act_irq,
  input  logic [NSRC-1:0]             act_fiq,
  output logic [NSLOT*HIR_ID_W-1:0]   slot_ids,
  output logic [NSLOT-1:0]            hit_irq,
  output logic [NSLOT-1:0]            hit_fiq
);
  localparam int unsigned IDSPACE = 1 << HIR_ID_W;

  logic [IDSPACE-1:0] irq_pad, fiq_pad;
  assign irq_pad = IDSPACE'(act_irq);
  assign fiq_pad = IDSPACE'(act_fiq);

  function automatic logic slot_live(input logic v, input logic [HIR_ID_W-1:0] id);
    return v && (int'(id) < int'(NSRC));
  endfunction

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [HIR_SLOT_W-1:0] fld;
    logic [HIR_ID_W-1:0]   id;
    logic                  part;
    logic                  unused_noise;
    assign fld          = slot_cfg[i*HIR_SLOT_W +: HIR_SLOT_W];
    assign id           = fld[HIR_ID_W-1:0];
    assign unused_noise = ^fld[HIR_SLOT_VBIT-1:HIR_ID_W];
    assign part         = slot_live(fld[HIR_SLOT_VBIT], id);
    assign slot_ids[i*HIR_ID_W +: HIR_ID_W] = id;
    assign hit_irq[i]   = part & irq_pad[id];
    assign hit_fiq[i]   = part & fiq_pad[id];
  end

  // R2: a slot naming an out-of-range id never produces a hit
  always_comb begin
    for (int k = 0; k < int'(NSLOT); k++) begin
      if (int'(slot_ids[k*HIR_ID_W +: HIR_ID_W]) >= int'(NSRC))
        a_r2_no_hit_out_of_range: assert (!hit_irq[k] && !hit_fiq[k]);
    end
  end
endmodule

// File: rtl/hir_pick.sv
module hir_pick #(
  parameter int unsigned N    = 40,
  parameter int unsigned IDXW = $clog2(N)
) (
  input  logic [N-1:0]    req,
  output logic            found,
  output logic [IDXW-1:0] idx,
  output logic [N-1:0]    grant
);
  function automatic logic [IDXW-1:0] first_set(input logic [N-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int k = int'(N) - 1; k >= 0; k--) begin
      if (v[k]) r = IDXW'(k);
    end
    return r;
  endfunction

  assign found = |req;
  assign idx   = first_set(req);
  assign grant = req & (~req + N'(1));

  // R5: the reported index is a requester with no lower requester
  always_comb begin
    a_r5_grant_onehot: assert ($onehot0(grant));
    if (found) begin
      a_r5_index_requests: assert (req[idx]);
      a_r5_index_matches_grant: assert (grant[idx]);
      for (int k = 0; k < int'(N); k++) begin
        if (k < int'(idx)) a_r5_nothing_lower: assert (!req[k]);
      end
    end
  end
endmodule

// File: rtl/hir_resolver.sv
module hir_resolver
  import hir_pkg::*;
#(
  parameter int unsigned NSLOT = 40,
  parameter int unsigned NSRC  = 40
) (
  input  logic [31:0]                 pend_lo,
  input  logic [31:0]                 pend_hi,
  input  logic [31:0]                 en_lo,
  input  logic [31:0]                 en_hi,
  input  logic [31:0]                 steer_lo,
  input  logic [31:0]                 steer_hi,
  input  logic [NSLOT*HIR_SLOT_W-1:0] slot_cfg,
  output logic [31:0]                 status
);
  localparam int unsigned IDXW = $clog2(NSLOT);

  logic [NSRC-1:0]           act_irq, act_fiq;
  logic [NSLOT*HIR_ID_W-1:0] slot_ids;
  logic [NSLOT-1:0]          hit_irq, hit_fiq;
  logic [NSLOT-1:0]          gnt_irq, gnt_fiq;
  logic                      irq_found, fiq_found;
  logic [IDXW-1:0]           irq_idx, fiq_idx;
  logic [HIR_ID_W-1:0]       irq_id, fiq_id;

  hir_src_qualify #(.NSRC(NSRC), .BANK_W(HIR_BANK_W)) u_qual (
    .pend    ({pend_hi, pend_lo}),
    .en      ({en_hi, en_lo}),
    .steer   ({steer_hi, steer_lo}),
    .act_irq (act_irq),
    .act_fiq (act_fiq)
  );

  hir_slot_eval #(.NSLOT(NSLOT), .NSRC(NSRC)) u_slots (
    .slot_cfg (slot_cfg),
    .act_irq  (act_irq),
    .act_fiq  (act_fiq),
    .slot_ids (slot_ids),
    .hit_irq  (hit_irq),
    .hit_fiq  (hit_fiq)
  );

  hir_pick #(.N(NSLOT), .IDXW(IDXW)) u_pick_irq (
    .req (hit_irq), .found (irq_found), .idx (irq_idx), .grant (gnt_irq)
  );

  hir_pick #(.N(NSLOT), .IDXW(IDXW)) u_pick_fiq (
    .req (hit_fiq), .found (fiq_found), .idx (fiq_idx), .grant (gnt_fiq)
  );

  assign irq_id = slot_ids[irq_idx*HIR_ID_W +: HIR_ID_W];
  assign fiq_id = slot_ids[fiq_idx*HIR_ID_W +: HIR_ID_W];
  assign status = {hir_half(irq_found, irq_id), hir_half(fiq_found, fiq_id)};

  always_comb begin
    // R8: the gap bits of both halves stay clear
    a_r8_gap_bits_zero: assert (status[30:22] == '0 && status[14:6] == '0);
    // R7: an idle half carries the fixed code
    if (!status[31]) a_r7_irq_idle_code: assert (status[21:16] == 6'h3F);
    if (!status[15]) a_r7_fiq_idle_code: assert (status[5:0] == 6'h3F);
    // R2/R6: a reported winner is a legal source for its line
    if (status[31]) begin
      a_r2_irq_id_legal: assert (int'(status[21:16]) < int'(NSRC));
      a_r6_irq_src_active: assert (act_irq[status[21:16]]);
    end
    if (status[15]) begin
      a_r2_fiq_id_legal: assert (int'(status[5:0]) < int'(NSRC));
      a_r6_fiq_src_active: assert (act_fiq[status[5:0]]);
    end
    // R5: each grant corresponds to its line's hit vector
    a_r5_irq_grant_hit: assert ((gnt_irq & ~hit_irq) == '0);
    a_r5_fiq_grant_hit: assert ((gnt_fiq & ~hit_fiq) == '0);
  end
endmodule

// File: tb/sim_hir_resolver.sv
module sim_hir_resolver;
  localparam int NSLOT = 40;
  localparam int NSRC  = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pend_lo, pend_hi, en_lo, en_hi, steer_lo, steer_hi;
  logic [NSLOT*32-1:0] slot_cfg;
  logic [31:0] status;
  logic [31:0] slots [NSLOT];

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  hir_resolver #(.NSLOT(NSLOT), .NSRC(NSRC)) u0 (
    .pend_lo(pend_lo), .pend_hi(pend_hi), .en_lo(en_lo), .en_hi(en_hi),
    .steer_lo(steer_lo), .steer_hi(steer_hi), .slot_cfg(slot_cfg), .status(status)
  );

  function automatic bit src_bit(input logic [31:0] lo, input logic [31:0] hi, input int id);
    return (id >= 32) ? hi[id-32] : lo[id];
  endfunction

  // Scan slots from the last to the first; each qualifying slot overwrites.
  function automatic logic [31:0] model();
    logic [15:0] ih, fh;
    ih = 16'h003F;
    fh = 16'h003F;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      int id;
      bit live;
      id = int'(slots[i][5:0]);
      if (slots[i][31] && id < NSRC) begin
        live = src_bit(pend_lo, pend_hi, id) && src_bit(en_lo, en_hi, id);
        if (live && src_bit(steer_lo, steer_hi, id)) fh = 16'h8000 | 16'(id);
        if (live && !src_bit(steer_lo, steer_hi, id)) ih = 16'h8000 | 16'(id);
      end
    end
    return {ih, fh};
  endfunction

  task automatic pack();
    for (int i = 0; i < NSLOT; i++) slot_cfg[i*32 +: 32] = slots[i];
  endtask

  task automatic clear_all();
    pend_lo = '0; pend_hi = '0; en_lo = '0; en_hi = '0; steer_lo = '0; steer_hi = '0;
    for (int i = 0; i < NSLOT; i++) slots[i] = '0;
    pack();
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    tests++;
    if (status !== exp) begin
      fails++;
      $display("FAIL %s: status=%08h expected=%08h", req, status, exp);
    end
  endtask

  task automatic settle_check(input string req, input logic [31:0] exp);
    @(negedge clk);
    pack();
    #1;
    check(req, exp);
  endtask

  function automatic logic [31:0] slot(input int id);
    return 32'h8000_0000 | 32'(id);
  endfunction

  initial begin
    #1600000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_all();
    #1;
    // R7: idle inputs give the fixed code in both halves
    check("R7", 32'h003F_003F);

    // R4/R6: single IRQ source in the low bank
    @(negedge clk); clear_all();
    slots[5] = slot(3); pend_lo[3] = 1; en_lo[3] = 1;
    settle_check("R6", 32'h8003_003F);

    // R4/R6: same source steered to FIQ
    steer_lo[3] = 1;
    settle_check("R4", 32'h003F_8003);

    // R4: enable cleared -> no candidate
    en_lo[3] = 0;
    settle_check("R4", 32'h003F_003F);

    // R3: high bank ID 35 uses bank bit 3
    @(negedge clk); clear_all();
    slots[0] = slot(35); pend_hi[3] = 1; en_hi[3] = 1;
    settle_check("R3", 32'h8023_003F);
    // R3: the low bank bit 3 alone does not light ID 35
    pend_hi[3] = 0; pend_lo[3] = 1; en_lo[3] = 1;
    settle_check("R3", 32'h003F_003F);

    // R2: IDs 40..63 ignored even with everything active
    @(negedge clk); clear_all();
    pend_lo = '1; pend_hi = '1; en_lo = '1; en_hi = '1;
    slots[0] = slot(45); slots[1] = slot(63); slots[2] = slot(40);
    settle_check("R2", 32'h003F_003F);
    // R2: disabled slot ignored
    slots[3] = 32'h0000_0007;
    settle_check("R2", 32'h003F_003F);

    // R1: noise in bits 30:6 has no effect
    slots[4] = 32'hFFFF_FFC7;
    settle_check("R1", 32'h8007_003F);

    // R5: lowest slot index wins over lower source number
    @(negedge clk); clear_all();
    pend_lo = '1; en_lo = '1;
    slots[2] = slot(10); slots[9] = slot(4);
    settle_check("R5", 32'h800A_003F);

    // R9: duplicate IDs, lowest slot still decides
    slots[1] = slot(10); slots[3] = slot(10);
    settle_check("R9", 32'h800A_003F);

    // R5: IRQ and FIQ resolved independently
    @(negedge clk); clear_all();
    pend_lo = '1; en_lo = '1; steer_lo[1] = 1;
    slots[0] = slot(1); slots[1] = slot(2); slots[7] = slot(9);
    settle_check("R5", 32'h8002_8001);

    // R8: gap bits zero with both halves valid at max IDs
    @(negedge clk); clear_all();
    pend_hi = '1; en_hi = '1; steer_hi[7] = 1;
    slots[39] = slot(39); slots[38] = slot(38);
    settle_check("R8", 32'h8026_8027);

    // R10: status follows inputs mid-cycle with no clock edge
    @(posedge clk); #1;
    pend_hi[6] = 0;
    #1;
    check("R10", 32'h003F_8027);

    // R5/R9 random mix against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      pend_lo = $urandom() & $urandom(); pend_hi = $urandom() & $urandom();
      en_lo = $urandom() | $urandom();   en_hi = $urandom() | $urandom();
      steer_lo = $urandom();             steer_hi = $urandom();
      for (int i = 0; i < NSLOT; i++) begin
        logic [31:0] w;
        w = $urandom();
        w[31] = ($urandom() % 5) != 0;
        w[5:0] = 6'($urandom() % 48);
        slots[i] = w;
      end
      pack();
      #1;
      check("R5", model());
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule